// File: doc/BRIEF.md
# Self-refresh power state controller

This block is the power-state sequencer of a DRAM controller. It moves the memory between normal operation, a power-down state and three substates of self-refresh that software selects. Software writes a power-control word. Bit 0 allows automatic power-down after a run of idle cycles. Bit 5 requests self-refresh. Bit 6 holds the memory in self-refresh. The block turns changes of bits 5 and 6 into substate moves and issues a one-cycle command strobe to the memory sequencer for each move.

Status goes back to software in a 10-bit word. Bits 2:0 carry an operating mode: 1 for normal, 2 for power-down and 3 for any self-refresh substate. Bits 9:8 carry the self-refresh substate: 0 idle, 1 first stage, 2 power-down inside self-refresh and 3 second stage. Software enters self-refresh only when the command queue is empty; until then a request stays pending. When self-refresh ends, a loadable down-counter holds the reported state at self-refresh for the programmed exit time. Only after that does the block report normal with substate 0.

Top module: `sref_pwr_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, the status word reads mode 1 and substate 0, and all four strobes are low.
- R2: From normal, with pwr_ctl bits 5 and 6 both 1 and queue_empty high, the next clock edge gives mode 3 and substate 1, and sr_enter is high for exactly one cycle.
- R3: While the queue is not empty, a request with bits 5 and 6 set leaves the mode unchanged. On the first edge at which queue_empty is high, the block moves to substate 1.
- R4: In substate 1 or 3, bit 5 set with bit 6 clear gives substate 2 (mode 3) on the next edge, with a one-cycle pd_enter.
- R5: In substate 2, bit 6 set with bit 5 clear gives substate 3 (mode 3) on the next edge, with a one-cycle pd_exit.
- R6: In any self-refresh substate, a request that leaves bits 5 and 6 both clear starts the exit and gives a one-cycle sr_exit. After the edge that starts the exit, mode 3 and the previous substate remain for exit_cycles+1 cycles, and then mode 1 with substate 0 follows.
- R7: With bit 0 set and queue_empty high for IDLE_CYC consecutive edges in normal, the block moves to mode 2 with a one-cycle pd_enter. With bit 0 clear it stays at mode 1. In power-down, queue_empty low or bit 0 clear returns the block to mode 1 on the next edge, with a one-cycle pd_exit.
- R8: From power-down, bits 5 and 6 set give mode 3 and substate 1 on the next edge. Only sr_enter pulses.
- R9: Status bits 7:3 always read 0, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ctl | input | 8 | Power-control word: bit 0 automatic power-down enable, bit 5 self-refresh request, bit 6 self-refresh hold; other bits have no effect |
| queue_empty | input | 1 | High when the command queue holds no commands |
| exit_cycles | input | EXIT_W | Self-refresh exit wait in cycles, loaded when an exit starts |
| stat_word | output | 10 | Status: bits 2:0 operating mode, bits 9:8 self-refresh substate, others 0 |
| sr_enter | output | 1 | One-cycle strobe: enter self-refresh |
| sr_exit | output | 1 | One-cycle strobe: exit self-refresh |
| pd_enter | output | 1 | One-cycle strobe: enter power-down |
| pd_exit | output | 1 | One-cycle strobe: exit power-down |

## Verification
Every substate move and its strobe is due on the first clock edge after the stimulus. The bench therefore drives inputs at a falling edge and checks at the next falling edge, with exactly one rising edge between them. The exit window is checked at both boundaries. Mode 3 must still show exit_cycles edges after the strobe, and mode 1 must show one edge later; this is done once with a wait of 5 and once with a wait of 0. The automatic power-down is checked one edge before and at the IDLE_CYC-th qualifying edge, and strobes are checked again one cycle later to confirm they have dropped.

// File: rtl/sref_pkg.sv
package sref_pkg;

  typedef enum logic [2:0] {
    ST_NORM = 3'd0,
    ST_PD   = 3'd1,
    ST_SR1  = 3'd2,
    ST_SRPD = 3'd3,
    ST_SR2  = 3'd4,
    ST_SRX  = 3'd5
  } sr_state_t;

  localparam int BIT_AUTO = 0;
  localparam int BIT_REQ  = 5;
  localparam int BIT_HOLD = 6;

  localparam logic [2:0] MODE_NORM = 3'd1;
  localparam logic [2:0] MODE_PD   = 3'd2;
  localparam logic [2:0] MODE_SR   = 3'd3;

  function automatic logic [2:0] mode_of(sr_state_t s);
    case (s)
      ST_NORM: mode_of = MODE_NORM;
      ST_PD:   mode_of = MODE_PD;
      default: mode_of = MODE_SR;
    endcase
  endfunction

  function automatic logic [1:0] sub_of(sr_state_t s);
    case (s)
      ST_SR1:  sub_of = 2'd1;
      ST_SRPD: sub_of = 2'd2;
      ST_SR2:  sub_of = 2'd3;
      default: sub_of = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sref_idle_timer.sv
module sref_idle_timer #(
  parameter int IDLE_CYC = 8,
  parameter int W        = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  logic [W-1:0] cnt;

  assign done = en && (cnt == W'(IDLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sref_exit_timer.sv
module sref_exit_timer #(
  parameter int EXIT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [EXIT_W-1:0] load_val,
  output logic              done
);
  logic [EXIT_W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sref_fsm.sv
module sref_fsm
  import sref_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      auto_en,
  input  logic      sw_req,
  input  logic      sw_hold,
  input  logic      q_empty,
  input  logic      idle_done,
  input  logic      exit_done,
  output sr_state_t state,
  output logic      idle_en,
  output logic      exit_load,
  output logic [2:0] mode_q,
  output logic [1:0] sub_q,
  output logic      sr_enter_q,
  output logic      sr_exit_q,
  output logic      pd_enter_q,
  output logic      pd_exit_q
);
  sr_state_t nxt;
  logic      enter_ok;

  assign enter_ok = sw_req && sw_hold && q_empty;
  assign idle_en  = (state == ST_NORM) && auto_en && q_empty && !(sw_req && sw_hold);

  always_comb begin
    nxt = state;
    case (state)
      ST_NORM: begin
        if (enter_ok)       nxt = ST_SR1;
        else if (idle_done) nxt = ST_PD;
      end
      ST_PD: begin
        if (enter_ok)                nxt = ST_SR1;
        else if (!q_empty || !auto_en) nxt = ST_NORM;
      end
      ST_SR1, ST_SR2: begin
        if (!sw_hold) nxt = sw_req ? ST_SRPD : ST_SRX;
      end
      ST_SRPD: begin
        if (!sw_req) nxt = sw_hold ? ST_SR2 : ST_SRX;
      end
      ST_SRX: begin
        if (exit_done) nxt = ST_NORM;
      end
      default: nxt = ST_NORM;
    endcase
  end

  assign exit_load = (state != ST_SRX) && (nxt == ST_SRX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_NORM;
      mode_q     <= MODE_NORM;
      sub_q      <= 2'd0;
      sr_enter_q <= 1'b0;
      sr_exit_q  <= 1'b0;
      pd_enter_q <= 1'b0;
      pd_exit_q  <= 1'b0;
    end else begin
      state      <= nxt;
      mode_q     <= mode_of(nxt);
      if (nxt != ST_SRX) sub_q <= sub_of(nxt);
      sr_enter_q <= (state == ST_NORM || state == ST_PD) && (nxt == ST_SR1);
      sr_exit_q  <= exit_load;
      pd_enter_q <= ((state == ST_NORM) && (nxt == ST_PD)) ||
                    ((state == ST_SR1 || state == ST_SR2) && (nxt == ST_SRPD));
      pd_exit_q  <= ((state == ST_PD) && (nxt == ST_NORM)) ||
                    ((state == ST_SRPD) && (nxt == ST_SR2));
    end
  end
endmodule

// File: rtl/sref_pwr_ctrl.sv
module sref_pwr_ctrl
  import sref_pkg::*;
#(
  parameter int EXIT_W   = 10,
  parameter int IDLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        pwr_ctl,
  input  logic              queue_empty,
  input  logic [EXIT_W-1:0] exit_cycles,
  output logic [9:0]        stat_word,
  output logic              sr_enter,
  output logic              sr_exit,
  output logic              pd_enter,
  output logic              pd_exit
);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);

  sr_state_t  st;
  logic       idle_en, idle_done, exit_load, exit_done;
  logic [2:0] mode_q;
  logic [1:0] sub_q;
  logic       unused_ctl;

  assign unused_ctl = ^{pwr_ctl[7], pwr_ctl[4:1]};

  sref_idle_timer #(.IDLE_CYC(IDLE_CYC), .W(IDLE_W)) u_idle (
    .clk(clk), .rst(rst), .en(idle_en), .done(idle_done)
  );

  sref_exit_timer #(.EXIT_W(EXIT_W)) u_exit (
    .clk(clk), .rst(rst), .load(exit_load), .load_val(exit_cycles), .done(exit_done)
  );

  sref_fsm u_fsm (
    .clk(clk), .rst(rst),
    .auto_en(pwr_ctl[BIT_AUTO]), .sw_req(pwr_ctl[BIT_REQ]), .sw_hold(pwr_ctl[BIT_HOLD]),
    .q_empty(queue_empty), .idle_done(idle_done), .exit_done(exit_done),
    .state(st), .idle_en(idle_en), .exit_load(exit_load),
    .mode_q(mode_q), .sub_q(sub_q),
    .sr_enter_q(sr_enter), .sr_exit_q(sr_exit), .pd_enter_q(pd_enter), .pd_exit_q(pd_exit)
  );

  assign stat_word = {sub_q, 5'd0, mode_q};
endmodule

// File: rtl/sref_pwr_ctrl_chk.sv
module sref_pwr_ctrl_chk
  import sref_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] pwr_ctl,
  input logic       queue_empty,
  input logic [9:0] stat_word,
  input logic       sr_enter,
  input logic       sr_exit,
  input logic       pd_enter,
  input logic       pd_exit,
  input sr_state_t  st,
  input logic       exit_done
);
  logic req, hold;
  assign req  = pwr_ctl[BIT_REQ];
  assign hold = pwr_ctl[BIT_HOLD];

  // R2
  sr1_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NORM && req && hold && queue_empty) |=> (stat_word[9:8] == 2'd1 && sr_enter));

  // R3
  pending_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_NORM || st == ST_PD) && !queue_empty) |=> (stat_word[2:0] != MODE_SR));

  // R4
  srpd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_SR1 || st == ST_SR2) && req && !hold) |=> (st == ST_SRPD && pd_enter));

  // R5
  sr2_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SRPD && hold && !req) |=> (st == ST_SR2 && stat_word[9:8] == 2'd3 && pd_exit));

  // R6
  exit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SRX && !exit_done) |=> (st == ST_SRX && stat_word[2:0] == MODE_SR && $stable(stat_word)));

  // R6
  exit_done_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SRX && exit_done) |=> (stat_word[2:0] == MODE_NORM && stat_word[9:8] == 2'd0));

  // R7
  pd_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PD && !queue_empty) |=> (st == ST_NORM && pd_exit));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sr_enter, sr_exit, pd_enter, pd_exit}));

  // R9
  stat_gap_chk: assert property (@(posedge clk) disable iff (rst)
    stat_word[7:3] == 5'd0);
endmodule

bind sref_pwr_ctrl sref_pwr_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .pwr_ctl(pwr_ctl), .queue_empty(queue_empty),
  .stat_word(stat_word), .sr_enter(sr_enter), .sr_exit(sr_exit),
  .pd_enter(pd_enter), .pd_exit(pd_exit), .st(st), .exit_done(exit_done)
);

// File: tb/sim_sref_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_sref_pwr_ctrl;
  localparam int EXIT_W   = 10;
  localparam int IDLE_CYC = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [7:0]        pwr_ctl;
  logic              queue_empty;
  logic [EXIT_W-1:0] exit_cycles;
  logic [9:0]        stat_word;
  logic              sr_enter, sr_exit, pd_enter, pd_exit;

  int checks = 0;
  int errors = 0;

  sref_pwr_ctrl #(.EXIT_W(EXIT_W), .IDLE_CYC(IDLE_CYC)) u0 (
    .clk(clk), .rst(rst), .pwr_ctl(pwr_ctl), .queue_empty(queue_empty),
    .exit_cycles(exit_cycles), .stat_word(stat_word),
    .sr_enter(sr_enter), .sr_exit(sr_exit), .pd_enter(pd_enter), .pd_exit(pd_exit)
  );

  initial forever #2.5 clk = ~clk;

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // status and strobes: {sub, mode, sr_enter, sr_exit, pd_enter, pd_exit}
  function automatic logic [31:0] obs();
    return {23'd0, stat_word[9:8], stat_word[2:0], sr_enter, sr_exit, pd_enter, pd_exit};
  endfunction

  function automatic logic [31:0] expv(input logic [1:0] sub, input logic [2:0] mode,
                                       input logic [3:0] strb);
    return {23'd0, sub, mode, strb};
  endfunction

  task automatic drive(input logic auto_b, input logic req, input logic hold, input logic qe);
    pwr_ctl     = {1'b0, hold, req, 4'b1010, auto_b};
    queue_empty = qe;
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R9 status gap", {27'd0, stat_word[7:3]}, 32'd0);
    chk("R9 strobe count", $countones({sr_enter, sr_exit, pd_enter, pd_exit}) > 1, 32'd0);
  endtask

  // strobe bits: {sr_enter, sr_exit, pd_enter, pd_exit}
  task automatic t_reset();
    rst = 1'b1;
    drive(0, 0, 0, 1);
    exit_cycles = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", obs(), expv(2'd0, 3'd1, 4'b0000));
    rst = 1'b0;
    tick();
    chk("R1 after reset", obs(), expv(2'd0, 3'd1, 4'b0000));
  endtask

  task automatic t_sr_entry();
    drive(0, 1, 1, 1);
    tick();
    chk("R2 entry", obs(), expv(2'd1, 3'd3, 4'b1000));
    tick();
    chk("R2 strobe drop", obs(), expv(2'd1, 3'd3, 4'b0000));
  endtask

  task automatic t_srpd_moves();
    drive(0, 1, 0, 1);
    tick();
    chk("R4 from stage 1", obs(), expv(2'd2, 3'd3, 4'b0010));
    drive(0, 0, 1, 1);
    tick();
    chk("R5 to stage 2", obs(), expv(2'd3, 3'd3, 4'b0001));
    tick();
    chk("R5 strobe drop", obs(), expv(2'd3, 3'd3, 4'b0000));
    drive(0, 1, 0, 1);
    tick();
    chk("R4 from stage 2", obs(), expv(2'd2, 3'd3, 4'b0010));
    drive(0, 0, 1, 1);
    tick();
    chk("R5 again", obs(), expv(2'd3, 3'd3, 4'b0001));
  endtask

  task automatic t_exit(input int n, input logic [1:0] sub);
    exit_cycles = EXIT_W'(n);
    drive(0, 0, 0, 1);
    tick();
    chk("R6 exit strobe", obs(), expv(sub, 3'd3, 4'b0100));
    if (n > 0) begin
      repeat (n) tick();
      chk("R6 still in wait", obs(), expv(sub, 3'd3, 4'b0000));
    end
    tick();
    chk("R6 back to normal", obs(), expv(2'd0, 3'd1, 4'b0000));
  endtask

  task automatic t_pending();
    drive(0, 1, 1, 0);
    repeat (3) tick();
    chk("R3 pending", obs(), expv(2'd0, 3'd1, 4'b0000));
    queue_empty = 1'b1;
    tick();
    chk("R3 accepted", obs(), expv(2'd1, 3'd3, 4'b1000));
  endtask

  task automatic t_auto_pd();
    drive(0, 0, 0, 1);
    repeat (IDLE_CYC + 4) tick();
    chk("R7 disabled stays normal", obs(), expv(2'd0, 3'd1, 4'b0000));
    drive(1, 0, 0, 1);
    repeat (IDLE_CYC - 1) tick();
    chk("R7 before idle limit", obs(), expv(2'd0, 3'd1, 4'b0000));
    tick();
    chk("R7 power-down", obs(), expv(2'd0, 3'd2, 4'b0010));
    drive(1, 0, 0, 0);
    tick();
    chk("R7 wake on traffic", obs(), expv(2'd0, 3'd1, 4'b0001));
    drive(1, 0, 0, 1);
    repeat (IDLE_CYC) tick();
    chk("R7 power-down again", obs(), expv(2'd0, 3'd2, 4'b0010));
    drive(0, 0, 0, 1);
    tick();
    chk("R7 wake on disable", obs(), expv(2'd0, 3'd1, 4'b0001));
  endtask

  task automatic t_pd_to_sr();
    drive(1, 0, 0, 1);
    repeat (IDLE_CYC) tick();
    chk("R8 setup power-down", obs(), expv(2'd0, 3'd2, 4'b0010));
    drive(1, 1, 1, 1);
    tick();
    chk("R8 entry from power-down", obs(), expv(2'd1, 3'd3, 4'b1000));
    pwr_ctl[0] = 1'b0;
  endtask

  initial begin
    t_reset();
    t_sr_entry();
    t_srpd_moves();
    t_exit(5, 2'd3);
    t_sr_entry();
    t_exit(0, 2'd1);
    t_pending();
    t_exit(2, 2'd1);
    t_auto_pd();
    t_pd_to_sr();
    t_exit(1, 2'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule